// File: doc/BRIEF.md
# CAN Transmit Slot Manager

This block holds a small fixed set of transmit slots that sit between a host loading frames and a bit-level CAN engine that sends them. Each slot stores one complete frame (identifier, length code and up to eight data bytes) and a pending flag. The host presents a frame with a load request. In the same cycle it gets back either an acceptance with the number of the slot it was given, or a busy indication when every slot is taken.

The slots are not a queue. Among the pending slots, the block offers the one with the numerically lowest identifier to the engine, whatever order the frames were loaded in. While the engine holds a frame, that slot is in flight. A success report frees the slot and raises a one-cycle completion pulse for it. A failure report, whether from lost arbitration or a bus error, leaves the slot pending so that it is offered again. A per-slot abort input withdraws a pending frame that is not in flight and raises a one-cycle abort pulse.

Top module: `can_tx_slot_mgr`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty, `offer_valid` is low and all bits of `done_pulse` and `abort_pulse` are low.
- R2: A load request while at least one slot is empty raises `load_ack` in the same cycle, with `load_slot` equal to the lowest-numbered empty slot (slot 0 is the lowest). That slot holds the frame and is pending from the next cycle.
- R3: A load request while every slot is pending raises `load_busy`, keeps `load_ack` low and leaves every stored frame and pending flag unchanged.
- R4: When no transfer is in flight and at least one slot is pending, `offer_valid` is high and `offer_slot` names the pending slot with the numerically lowest identifier. Equal identifiers go to the lower slot number. While a transfer is in flight, `offer_valid` is low.
- R5: `offer_id`, `offer_len` and `offer_data` carry the stored contents of the offered slot. Data byte k sits at bits 8k+7 down to 8k. `engine_start` while `offer_valid` is high makes the offered slot the in-flight slot from the next cycle.
- R6: `engine_done_ok` during an in-flight transfer empties that slot and raises only its bit of `done_pulse` for exactly the next cycle. If `engine_done_ok` and `engine_done_fail` are both high, success wins.
- R7: `engine_done_fail` during an in-flight transfer ends it without a completion pulse. The slot stays pending and is offered again from the next cycle.
- R8: `abort_req[i]` on a pending slot empties it and raises `abort_pulse[i]` for exactly the next cycle. It is ignored when slot i is empty, is in flight, or is being started in the same cycle.
- R9: `engine_done_ok`, `engine_done_fail` and `engine_start` have no effect when they cannot apply: a report with nothing in flight, or a start with `offer_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | Host asks to store a frame |
| load_id | input | 11 | Identifier of the frame to store |
| load_len | input | 4 | Length code of the frame to store |
| load_data | input | 64 | Payload, byte k at bits 8k+7:8k |
| load_ack | output | 1 | Load accepted this cycle |
| load_busy | output | 1 | Load refused, all slots pending |
| load_slot | output | 2 | Slot given to the accepted load |
| offer_valid | output | 1 | A frame is offered to the engine |
| offer_slot | output | 2 | Slot being offered |
| offer_id | output | 11 | Identifier of the offered frame |
| offer_len | output | 4 | Length code of the offered frame |
| offer_data | output | 64 | Payload of the offered frame |
| engine_start | input | 1 | Engine takes the offered frame |
| engine_done_ok | input | 1 | In-flight frame sent successfully |
| engine_done_fail | input | 1 | In-flight frame lost arbitration or hit an error |
| abort_req | input | 3 | Per-slot withdrawal request |
| done_pulse | output | 3 | Per-slot completion pulse |
| abort_pulse | output | 3 | Per-slot abort pulse |

## Verification
The bench uses the default build: three slots, 11-bit identifiers and an eight-byte payload. With only three slots, the all-full refusal, the reuse of a freed low slot and the later-loaded-goes-first ordering all come up within a handful of loads. In the random phase, identifiers are drawn from a range of eight values, so slots often share an identifier and the tie rule on slot number is exercised repeatedly. The random phase also overlaps aborts, starts and reports in the same cycle, so the abort blocking rule and the success-over-failure rule are both hit.

// File: rtl/can_txm_pkg.sv
// Package: shared widths and the stored frame type for the transmit slot manager.
// Assumes standard CAN identifiers and at most eight payload bytes.
package can_txm_pkg;
    localparam int unsigned TXM_ID_W   = 11;
    localparam int unsigned TXM_LEN_W  = 4;
    localparam int unsigned TXM_BYTES  = 8;
    localparam int unsigned TXM_DATA_W = TXM_BYTES * 8;

    typedef struct packed {
        logic [TXM_ID_W-1:0]   id;
        logic [TXM_LEN_W-1:0]  len;
        logic [TXM_DATA_W-1:0] data;
    } txm_frame_t;
endpackage

// File: rtl/can_txm_slot.sv
// One transmit slot: frame storage, pending flag and the two status pulses.
// Assumes the parent only loads an empty slot and never asks to clear it
// for success and abort in the same cycle.
module can_txm_slot
    import can_txm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  txm_frame_t frame_in,
    input  logic       clear_ok,
    input  logic       clear_abort,
    output logic       pending,
    output txm_frame_t frame,
    output logic       done_pulse,
    output logic       abort_pulse
);
    logic pending_q;

    // Pending flag: set by a load, cleared by success or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (load_en)
            pending_q <= 1'b1;
        else if (clear_ok || clear_abort)
            pending_q <= 1'b0;
    end

    // Frame storage: captured only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (load_en)
            frame <= frame_in;
    end

    // Status pulses: one cycle after the clearing event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            done_pulse  <= clear_ok;
            abort_pulse <= clear_abort;
        end
    end

    assign pending = pending_q;
endmodule

// File: rtl/can_txm_free_pick.sv
// Finds the lowest-numbered empty slot.
// Assumes N >= 1. idx is zero when no slot is free.
module can_txm_free_pick #(
    parameter int unsigned N     = 3,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     occupied,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest free index is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_txm_prio_pick.sv
// Picks, among valid entries, the one with the lowest identifier; ties go
// to the lower index. Linear compare chain, suited to a handful of slots.
module can_txm_prio_pick #(
    parameter int unsigned N     = 3,
    parameter int unsigned ID_W  = 11,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [ID_W-1:0]  ids [N],
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [ID_W-1:0] best_id;

    // Walk up from index 0; replace only on a strictly lower identifier.
    always_comb begin
        found   = 1'b0;
        idx     = '0;
        best_id = '1;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!found || ids[i] < best_id)) begin
                found   = 1'b1;
                idx     = IDX_W'(i);
                best_id = ids[i];
            end
        end
    end
endmodule

// File: rtl/can_tx_slot_mgr.sv
// Transmit slot manager: stores frames in fixed slots, offers the highest
// priority pending frame to the bit engine, and tracks the one in-flight
// transfer until the engine reports success or failure.
// Assumes the engine raises at most one report per transfer and only
// after it has taken a frame with engine_start.
module can_tx_slot_mgr
    import can_txm_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 3,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_req,
    input  logic [TXM_ID_W-1:0]   load_id,
    input  logic [TXM_LEN_W-1:0]  load_len,
    input  logic [TXM_DATA_W-1:0] load_data,
    output logic                  load_ack,
    output logic                  load_busy,
    output logic [SLOT_W-1:0]     load_slot,
    output logic                  offer_valid,
    output logic [SLOT_W-1:0]     offer_slot,
    output logic [TXM_ID_W-1:0]   offer_id,
    output logic [TXM_LEN_W-1:0]  offer_len,
    output logic [TXM_DATA_W-1:0] offer_data,
    input  logic                  engine_start,
    input  logic                  engine_done_ok,
    input  logic                  engine_done_fail,
    input  logic [NUM_SLOTS-1:0]  abort_req,
    output logic [NUM_SLOTS-1:0]  done_pulse,
    output logic [NUM_SLOTS-1:0]  abort_pulse
);
    logic [NUM_SLOTS-1:0] slot_pending;
    txm_frame_t           slot_frame [NUM_SLOTS];
    logic [TXM_ID_W-1:0]  slot_id    [NUM_SLOTS];
    txm_frame_t           frame_in;

    logic                 free_found;
    logic [SLOT_W-1:0]    free_idx;
    logic                 cand_found;
    logic [SLOT_W-1:0]    cand_idx;

    logic                 inflight_q;
    logic [SLOT_W-1:0]    tx_slot_q;
    logic                 start_acc;
    logic                 ok_acc;
    logic                 fail_acc;
    txm_frame_t           offer_frame;

    assign frame_in = '{id: load_id, len: load_len, data: load_data};

    can_txm_free_pick #(.N(NUM_SLOTS)) u_free (
        .occupied (slot_pending),
        .found    (free_found),
        .idx      (free_idx)
    );

    can_txm_prio_pick #(.N(NUM_SLOTS), .ID_W(TXM_ID_W)) u_prio (
        .valid (slot_pending),
        .ids   (slot_id),
        .found (cand_found),
        .idx   (cand_idx)
    );

    // Host-side handshake, answered in the cycle of the request.
    assign load_ack  = load_req && free_found;
    assign load_busy = load_req && !free_found;
    assign load_slot = free_found ? free_idx : '0;

    // Engine-side event qualification.
    assign offer_valid = cand_found && !inflight_q;
    assign start_acc   = engine_start && offer_valid;
    assign ok_acc      = inflight_q && engine_done_ok;
    assign fail_acc    = inflight_q && engine_done_fail && !engine_done_ok;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic is_tx;
            logic starting;
            logic ld_en;
            logic clr_ok;
            logic clr_abort;

            assign is_tx     = inflight_q && (tx_slot_q == SLOT_W'(g));
            assign starting  = start_acc && (cand_idx == SLOT_W'(g));
            assign ld_en     = load_ack && (free_idx == SLOT_W'(g));
            assign clr_ok    = ok_acc && (tx_slot_q == SLOT_W'(g));
            assign clr_abort = abort_req[g] && slot_pending[g] && !is_tx && !starting;

            can_txm_slot u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .load_en     (ld_en),
                .frame_in    (frame_in),
                .clear_ok    (clr_ok),
                .clear_abort (clr_abort),
                .pending     (slot_pending[g]),
                .frame       (slot_frame[g]),
                .done_pulse  (done_pulse[g]),
                .abort_pulse (abort_pulse[g])
            );

            assign slot_id[g] = slot_frame[g].id;
        end
    endgenerate

    // In-flight tracker: one transfer at a time, ended by either report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
            tx_slot_q  <= '0;
        end else if (ok_acc || fail_acc) begin
            inflight_q <= 1'b0;
        end else if (start_acc) begin
            inflight_q <= 1'b1;
            tx_slot_q  <= cand_idx;
        end
    end

    // Offer mux: contents of the selected candidate slot.
    always_comb begin
        offer_frame = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (cand_idx == SLOT_W'(i))
                offer_frame = slot_frame[i];
        end
    end

    assign offer_slot = cand_idx;
    assign offer_id   = offer_frame.id;
    assign offer_len  = offer_frame.len;
    assign offer_data = offer_frame.data;
endmodule

// File: rtl/can_txm_checker.sv
// Property checker for the transmit slot manager, bound to the top module.
// Observes ports plus the pending flags and the in-flight register.
module can_txm_checker #(
    parameter int unsigned NUM_SLOTS = 3,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_req,
    input logic                 load_ack,
    input logic                 load_busy,
    input logic [SLOT_W-1:0]    load_slot,
    input logic                 offer_valid,
    input logic [SLOT_W-1:0]    offer_slot,
    input logic                 engine_done_ok,
    input logic [NUM_SLOTS-1:0] done_pulse,
    input logic [NUM_SLOTS-1:0] abort_pulse,
    input logic [NUM_SLOTS-1:0] slot_pending,
    input logic                 inflight_q
);
    // R3
    busy_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && (&slot_pending)) |-> (load_busy && !load_ack));

    // R3
    busy_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && !inflight_q && (abort_pulse == '0)) |-> !load_ack);

    // R2
    load_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> slot_pending[$past(load_slot)]);

    // R4
    no_offer_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !offer_valid);

    // R4
    offer_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> slot_pending[offer_slot]);

    // R6
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse));

    // R6
    done_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q && !engine_done_ok) |=> (done_pulse == '0));

    // R8
    abort_done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse & abort_pulse) == '0);
endmodule

bind can_tx_slot_mgr can_txm_checker #(.NUM_SLOTS(NUM_SLOTS)) u_txm_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_req       (load_req),
    .load_ack       (load_ack),
    .load_busy      (load_busy),
    .load_slot      (load_slot),
    .offer_valid    (offer_valid),
    .offer_slot     (offer_slot),
    .engine_done_ok (engine_done_ok),
    .done_pulse     (done_pulse),
    .abort_pulse    (abort_pulse),
    .slot_pending   (slot_pending),
    .inflight_q     (inflight_q)
);

// File: tb/test_can_tx_slot_mgr.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of the slot manager, compared every cycle.
module test_can_tx_slot_mgr;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic [10:0] load_id = '0;
    logic [3:0]  load_len = '0;
    logic [63:0] load_data = '0;
    logic        load_ack, load_busy;
    logic [1:0]  load_slot;
    logic        offer_valid;
    logic [1:0]  offer_slot;
    logic [10:0] offer_id;
    logic [3:0]  offer_len;
    logic [63:0] offer_data;
    logic        engine_start = 1'b0;
    logic        engine_done_ok = 1'b0;
    logic        engine_done_fail = 1'b0;
    logic [2:0]  abort_req = '0;
    logic [2:0]  done_pulse, abort_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    bit          m_pend [NS];
    int          m_id   [NS];
    int          m_len  [NS];
    logic [63:0] m_data [NS];
    bit          m_fly;
    int          m_tx;
    logic [2:0]  m_done, m_abort;

    always #2.5 clk = ~clk;

    can_tx_slot_mgr i_can_tx_slot_mgr (
        .clk(clk), .rst_n(rst_n),
        .load_req(load_req), .load_id(load_id), .load_len(load_len), .load_data(load_data),
        .load_ack(load_ack), .load_busy(load_busy), .load_slot(load_slot),
        .offer_valid(offer_valid), .offer_slot(offer_slot), .offer_id(offer_id),
        .offer_len(offer_len), .offer_data(offer_data),
        .engine_start(engine_start), .engine_done_ok(engine_done_ok),
        .engine_done_fail(engine_done_fail), .abort_req(abort_req),
        .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int free_slot();
        for (int i = 0; i < NS; i++) if (!m_pend[i]) return i;
        return -1;
    endfunction

    function automatic int best_slot();
        int b = -1;
        for (int i = 0; i < NS; i++)
            if (m_pend[i] && (b < 0 || m_id[i] < m_id[b])) b = i;
        return b;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_pend[i] = 0; m_id[i] = 0; m_len[i] = 0; m_data[i] = '0;
        end
        m_fly = 0; m_tx = 0; m_done = '0; m_abort = '0;
    endtask

    task automatic compare();
        int f = free_slot();
        int b = best_slot();
        bit ov = (b >= 0) && !m_fly;
        chk(load_ack == (load_req && f >= 0), "R2", "load_ack", 64'(load_ack), 64'(load_req && f >= 0));
        chk(load_busy == (load_req && f < 0), "R3", "load_busy", 64'(load_busy), 64'(load_req && f < 0));
        if (load_req && f >= 0)
            chk(load_slot == 2'(f), "R2", "load_slot", 64'(load_slot), 64'(f));
        chk(offer_valid == ov, "R4", "offer_valid", 64'(offer_valid), 64'(ov));
        if (ov) begin
            chk(offer_slot == 2'(b), "R4", "offer_slot", 64'(offer_slot), 64'(b));
            chk(offer_id == 11'(m_id[b]) && offer_len == 4'(m_len[b]) && offer_data == m_data[b],
                "R5", "offer_fields", offer_data, m_data[b]);
        end
        chk(done_pulse == m_done, "R6", "done_pulse", 64'(done_pulse), 64'(m_done));
        chk(abort_pulse == m_abort, "R8", "abort_pulse", 64'(abort_pulse), 64'(m_abort));
    endtask

    task automatic model_update();
        int f = free_slot();
        int b = best_slot();
        bit ov = (b >= 0) && !m_fly;
        bit st = engine_start && ov;
        bit pre_fly = m_fly;
        int pre_tx = m_tx;
        m_done = '0; m_abort = '0;
        for (int i = 0; i < NS; i++)
            if (abort_req[i] && m_pend[i] && !(pre_fly && pre_tx == i) && !(st && b == i)) begin
                m_pend[i] = 0; m_abort[i] = 1'b1;
            end
        if (pre_fly && engine_done_ok) begin
            m_pend[pre_tx] = 0; m_done[pre_tx] = 1'b1; m_fly = 0;
        end else if (pre_fly && engine_done_fail) begin
            m_fly = 0;
        end else if (st) begin
            m_fly = 1; m_tx = b;
        end
        if (load_req && f >= 0) begin
            m_pend[f] = 1; m_id[f] = int'(load_id); m_len[f] = int'(load_len); m_data[f] = load_data;
        end
    endtask

    task automatic cyc();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        load_req = 0; engine_start = 0; engine_done_ok = 0; engine_done_fail = 0; abort_req = '0;
    endtask

    task automatic load(input int id, input int len, input logic [63:0] d);
        load_req = 1; load_id = 11'(id); load_len = 4'(len); load_data = d;
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(!offer_valid && done_pulse == 0 && abort_pulse == 0, "R1", "reset_outputs",
            64'({offer_valid, done_pulse, abort_pulse}), 64'(0));
        @(negedge clk);
        rst_n = 1;
        cyc();

        // R2: fill in order, later lower id wins (R4)
        load(11'h300, 8, 64'h1111_2222_3333_4444);
        load(11'h100, 2, 64'h0000_0000_0000_BEEF);
        load(11'h200, 4, 64'h0000_0000_CAFE_F00D);
        // R3: fourth load refused
        load(11'h010, 1, 64'h55);
        #1;
        chk(offer_valid && offer_slot == 2'd1 && offer_id == 11'h100, "R3", "contents_unchanged",
            64'(offer_id), 64'h100);
        cyc();

        // R5: take slot 1; R7: fail keeps it pending
        engine_start = 1; cyc();
        engine_done_fail = 1; cyc();
        #1;
        chk(offer_valid && offer_slot == 2'd1, "R7", "reoffer_after_fail", 64'(offer_slot), 64'd1);
        engine_start = 1; cyc();
        // R6: success frees slot 1
        engine_done_ok = 1; cyc();
        cyc();
        // R2: freed slot 1 is the lowest empty one
        load(11'h050, 3, 64'h0000_0000_00AB_CDEF);
        // R8: abort slot 2 while idle
        abort_req = 3'b100; cyc();
        cyc();
        // R8: abort on the slot being started is ignored
        engine_start = 1; abort_req = 3'b010; cyc();
        // R8: abort on the in-flight slot and on an empty slot are ignored
        abort_req = 3'b110; cyc();
        cyc();
        engine_done_ok = 1; cyc();
        cyc();
        // R9: reports with nothing in flight are ignored
        engine_done_ok = 1; engine_done_fail = 1; cyc();
        #1;
        chk(done_pulse == 0 && offer_valid && offer_slot == 2'd0, "R9", "spurious_report",
            64'(offer_slot), 64'd0);
        cyc();
        // R4: tie on identifier goes to the lower slot
        load(11'h300, 1, 64'h9);
        load(11'h300, 1, 64'hA);
        abort_req = 3'b001; cyc();
        cyc();
        #1;
        chk(offer_valid && offer_slot == 2'd1, "R4", "tie_lower_index", 64'(offer_slot), 64'd1);
        cyc();

        // Random phase with narrow identifier range
        for (int n = 0; n < 3000; n++) begin
            load_req = ($urandom_range(0, 9) < 4);
            load_id = 11'($urandom_range(0, 7));
            load_len = 4'($urandom_range(0, 8));
            load_data = {$urandom(), $urandom()};
            engine_start = ($urandom_range(0, 3) == 0);
            engine_done_ok = ($urandom_range(0, 4) == 0);
            engine_done_fail = ($urandom_range(0, 5) == 0);
            abort_req = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
            cyc();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule